// File: doc/BRIEF.md
# Seed and Security Code Block-Transfer Engine

This block sits behind a byte-level SMBus slave front end and serves three block commands. The host can store a 64-bit seed, read that seed back, and fetch a 64-bit pseudo-random security code. The code is drawn from a 63-bit linear feedback shift register (LFSR). The LFSR is loaded from the seed mixed with a fixed 16-bit manufacturer identifier. That identifier is a parameter, and no command can read it or write it. After every completed code read the register moves on by a fixed number of steps, so two reads in a row never return the same code. Host software that knows the identifier can compute the expected code from the seed it stored. A board whose code does not match is flagged as cloned.

The front end handles bit timing, address matching and the address acknowledge. It reports bus events to this block as one-cycle strobes: START, repeated START, STOP and address match (with the read/write bit). Each received byte arrives with `rx_valid`, and the block answers on `rx_ack` in the same cycle. For reads, the front end pulses `tx_req`, and the block returns the byte one cycle later on `tx_valid`/`tx_data`. The master's acknowledge for that byte is then reported on `tx_ack_valid`/`tx_ack`.

The command state machine has eight states:
- IDLE: waits for an address.
- CMD: an address with the write bit was matched and the command byte is expected.
- COUNT: seed-write command seen; the count byte is expected.
- SEED: collecting seed bytes.
- WAIT_RD: a read command is latched; waiting for the repeated START and the read address.
- SEND_CNT: the count byte goes out next.
- SEND_DATA: data bytes go out.
- DEAD: the transaction is refused or finished; bytes received are NACKed and bytes sent read 0xFF.

Transitions:
- STOP or START: any state to IDLE.
- Repeated START: any state to IDLE, except WAIT_RD, which stays.
- Address match from IDLE: write goes to CMD, read goes to DEAD.
- Address match from WAIT_RD: read goes to SEND_CNT, write goes to DEAD.
- Address match from any other state: DEAD.
- CMD: 0xC0 goes to COUNT; 0xC1 or 0xC3 goes to WAIT_RD; any other byte goes to DEAD.
- COUNT: 0x08 goes to SEED; any other byte goes to DEAD.
- SEND_CNT: `tx_req` goes to SEND_DATA.
- SEND_DATA: a NACK, or the acknowledge phase of the eighth data byte, goes to DEAD.

Top module: `seccode_xfer`

## Requirements
- R1: After reset the seed equals parameter SEED_INIT. A seed read returns count byte 0x08, then the seed bytes most significant first (bits 63:56 first).
- R2: A seed write is address(W), command 0xC0, count byte 0x08 and eight data bytes, each byte ACKed (`rx_ack`=1). The new seed takes effect at the STOP. The first data byte received becomes bits 63:56.
- R3: If fewer than eight seed bytes have arrived when STOP or a new START comes, the staged bytes are discarded and the seed keeps its old value.
- R4: A count byte other than 0x08 after 0xC0 is NACKed, and so is every later byte of that transaction; the seed is unchanged. A ninth seed byte is NACKed and does not alter the eight already staged.
- R5: Any command byte other than 0xC0, 0xC1 or 0xC3 is NACKed. A read in that transaction returns 0xFF bytes.
- R6: After 0xC1 or 0xC3, a repeated START and address(R), the block returns 0x08 and then eight data bytes, most significant first, each one cycle after `tx_req`. Bytes requested beyond the eighth, and reads not preceded by a read command in the same transaction, return 0xFF.
- R7: The code is {1'b1, L}, where L is the 63-bit LFSR state. L is loaded at reset and at each seed commit with bits 62:0 of (seed XOR the 16-bit MFG_ID repeated four times). An all-zero load value is replaced by 1.
- R8: After the acknowledge phase of the eighth code byte (ACK or NACK), L advances exactly 64 steps, one per clock. Each step shifts L one place toward the most significant bit, and the new bit 0 is bit 62 XOR bit 61.
- R9: A code read ended before the eighth byte, and any seed read, leave L unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | START seen (one-cycle strobe) |
| rstart_evt | input | 1 | Repeated START seen |
| stop_evt | input | 1 | STOP seen |
| addr_evt | input | 1 | Own address matched |
| addr_rd | input | 1 | Read/write bit of the matched address (1 = read) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | 1 = ACK the byte in `rx_data`, valid while `rx_valid` |
| tx_req | input | 1 | Front end requests the next byte to send |
| tx_valid | output | 1 | Byte on `tx_data` is valid (one cycle after `tx_req`) |
| tx_data | output | 8 | Byte to send |
| tx_ack_valid | input | 1 | Master acknowledge for the last sent byte is valid |
| tx_ack | input | 1 | 1 = master ACKed, 0 = NACKed |

## Verification
The bench writes seeds and compares every returned byte with a bench-side model of the mix and step rules. It also goes after the points where an engine is easy to get subtly wrong:
- Seeds equal to the repeated identifier force an all-zero load value; a design without the zero replacement would lock the code at 0x8000_0000_0000_0000.
- Partial writes ending in STOP or START at each byte count, bad count bytes and a ninth byte would corrupt the stored seed in a design that commits too early or shifts too many bytes.
- Code reads cut short at every byte position, and seed reads, must leave the code untouched; a design that advances on STOP or on any read would return a different code next time.
- A sweep of all 256 command values and extra trailing reads catch a decoder that accepts a near-miss command or keeps sending data past the count.

// File: rtl/seccode_pkg.sv
package seccode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_COUNT,
        ST_SEED,
        ST_WAIT_RD,
        ST_SEND_CNT,
        ST_SEND_DATA,
        ST_DEAD
    } xfer_state_t;

    localparam logic [7:0] CMD_SEED_WR = 8'hC0;
    localparam logic [7:0] CMD_SEED_RD = 8'hC1;
    localparam logic [7:0] CMD_CODE_RD = 8'hC3;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;

endpackage

// File: rtl/seccode_seed_store.sv
// Staging shift register plus committed seed register.
module seccode_seed_store #(
    parameter int              NBYTES    = 8,
    parameter int              WORD_W    = 8 * NBYTES,
    parameter logic [WORD_W-1:0] SEED_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_clr,
    input  logic              stg_push,
    input  logic [7:0]        push_byte,
    input  logic              commit,
    output logic [WORD_W-1:0] stg_q,
    output logic              stg_full,
    output logic [WORD_W-1:0] seed_q
);
    localparam int              CNT_W    = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBYTES);

    logic [CNT_W-1:0] cnt_q;

    assign stg_full = (cnt_q == CNT_FULL);

    // Staging: first byte ends up in the top octet after NBYTES shifts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
            cnt_q <= '0;
        end else if (stg_clr) begin
            cnt_q <= '0;
        end else if (stg_push) begin
            stg_q <= {stg_q[WORD_W-9:0], push_byte};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= SEED_INIT;
        end else if (commit) begin
            seed_q <= stg_q;
        end
    end

endmodule

// File: rtl/seccode_code_gen.sv
// 63-bit LFSR code generator with a serial multi-step advance.
module seccode_code_gen #(
    parameter int                WORD_W    = 64,
    parameter int                MID_W     = 16,
    parameter logic [MID_W-1:0]  MFG_ID    = '0,
    parameter logic [WORD_W-1:0] SEED_INIT = '0,
    parameter int                ADV_STEPS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_seed,
    input  logic              adv_go,
    output logic [WORD_W-1:0] code_q,
    output logic [WORD_W-2:0] lfsr_q,
    output logic              busy
);
    localparam int               LFSR_W = WORD_W - 1;
    localparam int               REPS   = WORD_W / MID_W;
    localparam int               STEP_W = $clog2(ADV_STEPS + 1);
    localparam logic [STEP_W-1:0] STEP_N = STEP_W'(ADV_STEPS);

    logic [STEP_W-1:0] steps_q;

    function automatic logic [LFSR_W-1:0] mix(input logic [WORD_W-1:0] seed);
        logic [WORD_W-1:0] rep;
        logic [WORD_W-1:0] x;
        logic [LFSR_W-1:0] r;
        rep = '0;
        for (int i = 0; i < REPS; i++) begin
            rep[i*MID_W +: MID_W] = MFG_ID;
        end
        x = seed ^ rep;
        r = x[LFSR_W-1:0];
        if (r == '0) begin
            r = LFSR_W'(1);
        end
        return r;
    endfunction

    function automatic logic [LFSR_W-1:0] step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q  <= mix(SEED_INIT);
            steps_q <= '0;
        end else if (load) begin
            lfsr_q  <= mix(load_seed);
            steps_q <= '0;
        end else if (adv_go) begin
            steps_q <= STEP_N;
        end else if (steps_q != '0) begin
            lfsr_q  <= step(lfsr_q);
            steps_q <= steps_q - 1'b1;
        end
    end

    assign busy   = (steps_q != '0);
    assign code_q = {1'b1, lfsr_q};

endmodule

// File: rtl/seccode_cmd_fsm.sv
// Command decoder and byte sequencer for the block transfers.
module seccode_cmd_fsm
    import seccode_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int WORD_W = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              rstart_evt,
    input  logic              stop_evt,
    input  logic              addr_evt,
    input  logic              addr_rd,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ack,
    input  logic              tx_req,
    input  logic              tx_ack_valid,
    input  logic              tx_ack,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic [WORD_W-1:0] rd_word,
    output logic              rd_code,
    input  logic              stg_full,
    output logic              stg_clr,
    output logic              stg_push,
    output logic              seed_commit,
    output logic              adv_go
);
    localparam int               IDX_W      = $clog2(NBYTES + 1);
    localparam logic [7:0]       COUNT_BYTE = 8'(NBYTES);
    localparam logic [IDX_W-1:0] IDX_END    = IDX_W'(NBYTES);

    xfer_state_t      state_q, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic             evt_none;
    logic             cmd_known;
    logic             cnt_ok;

    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                             input logic [IDX_W-1:0] i);
        int base;
        base = WORD_W - 8 - 8 * int'(i);
        return w[base +: 8];
    endfunction

    assign evt_none  = !stop_evt && !start_evt && !rstart_evt && !addr_evt;
    assign cmd_known = (rx_data == CMD_SEED_WR) || (rx_data == CMD_SEED_RD) ||
                       (rx_data == CMD_CODE_RD);
    assign cnt_ok    = (rx_data == COUNT_BYTE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        if (stop_evt || start_evt) begin
            state_nx = ST_IDLE;
        end else if (rstart_evt) begin
            state_nx = (state_q == ST_WAIT_RD) ? ST_WAIT_RD : ST_IDLE;
        end else if (addr_evt) begin
            if (state_q == ST_IDLE) begin
                state_nx = addr_rd ? ST_DEAD : ST_CMD;
            end else if (state_q == ST_WAIT_RD) begin
                state_nx = addr_rd ? ST_SEND_CNT : ST_DEAD;
            end else begin
                state_nx = ST_DEAD;
            end
        end else begin
            unique case (state_q)
                ST_CMD: begin
                    if (rx_valid) begin
                        if (rx_data == CMD_SEED_WR) begin
                            state_nx = ST_COUNT;
                        end else if (cmd_known) begin
                            state_nx = ST_WAIT_RD;
                        end else begin
                            state_nx = ST_DEAD;
                        end
                    end
                end
                ST_COUNT: begin
                    if (rx_valid) begin
                        state_nx = cnt_ok ? ST_SEED : ST_DEAD;
                    end
                end
                ST_SEND_CNT: begin
                    if (tx_req) begin
                        state_nx = ST_SEND_DATA;
                    end
                end
                ST_SEND_DATA: begin
                    if (tx_ack_valid && (!tx_ack || idx_q == IDX_END)) begin
                        state_nx = ST_DEAD;
                    end
                end
                ST_IDLE, ST_SEED, ST_WAIT_RD, ST_DEAD: begin
                    state_nx = state_q;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Combinational outputs
    always_comb begin
        rx_ack      = 1'b0;
        stg_clr     = 1'b0;
        stg_push    = 1'b0;
        adv_go      = 1'b0;
        seed_commit = stop_evt && (state_q == ST_SEED) && stg_full;
        if (evt_none) begin
            unique case (state_q)
                ST_CMD: begin
                    rx_ack = rx_valid && cmd_known;
                end
                ST_COUNT: begin
                    rx_ack  = rx_valid && cnt_ok;
                    stg_clr = rx_valid && cnt_ok;
                end
                ST_SEED: begin
                    rx_ack   = rx_valid && !stg_full;
                    stg_push = rx_valid && !stg_full;
                end
                ST_SEND_DATA: begin
                    adv_go = tx_ack_valid && (idx_q == IDX_END) && rd_code;
                end
                default: begin
                    rx_ack = 1'b0;
                end
            endcase
        end
    end

    // Registered outputs and sequencing state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            rd_code  <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= FILL_BYTE;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) begin
                if (state_q == ST_SEND_CNT) begin
                    tx_data <= COUNT_BYTE;
                end else if (state_q == ST_SEND_DATA && idx_q != IDX_END) begin
                    tx_data <= pick_byte(rd_word, idx_q);
                end else begin
                    tx_data <= FILL_BYTE;
                end
            end
            if (evt_none) begin
                if (state_q == ST_CMD && rx_valid) begin
                    rd_code <= (rx_data == CMD_CODE_RD);
                end
                if (state_q == ST_SEND_CNT && tx_req) begin
                    idx_q <= '0;
                end else if (state_q == ST_SEND_DATA && tx_req && idx_q != IDX_END) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seccode_xfer.sv
// Top: seed / security code block-transfer engine.
module seccode_xfer #(
    parameter int                    NBYTES    = 8,
    parameter int                    MID_W     = 16,
    parameter logic [MID_W-1:0]      MFG_ID    = 16'h5A3C,
    parameter logic [8*NBYTES-1:0]   SEED_INIT = 64'h0123_4567_89AB_CDEF,
    parameter int                    ADV_STEPS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic       rstart_evt,
    input  logic       stop_evt,
    input  logic       addr_evt,
    input  logic       addr_rd,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ack,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ack_valid,
    input  logic       tx_ack
);
    localparam int WORD_W = 8 * NBYTES;

    logic [WORD_W-1:0] seed_q;
    logic [WORD_W-1:0] stg_q;
    logic [WORD_W-1:0] code_q;
    logic [WORD_W-2:0] lfsr_q;
    logic [WORD_W-1:0] rd_word;
    logic              stg_full, stg_clr, stg_push, seed_commit;
    logic              adv_go, adv_busy, rd_code;

    assign rd_word = rd_code ? code_q : seed_q;

    seccode_cmd_fsm #(.NBYTES(NBYTES), .WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .rstart_evt(rstart_evt), .stop_evt(stop_evt),
        .addr_evt(addr_evt), .addr_rd(addr_rd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
        .tx_req(tx_req), .tx_ack_valid(tx_ack_valid), .tx_ack(tx_ack),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .rd_word(rd_word), .rd_code(rd_code),
        .stg_full(stg_full), .stg_clr(stg_clr), .stg_push(stg_push),
        .seed_commit(seed_commit), .adv_go(adv_go)
    );

    seccode_seed_store #(.NBYTES(NBYTES), .WORD_W(WORD_W), .SEED_INIT(SEED_INIT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .stg_clr(stg_clr), .stg_push(stg_push), .push_byte(rx_data),
        .commit(seed_commit), .stg_q(stg_q), .stg_full(stg_full), .seed_q(seed_q)
    );

    seccode_code_gen #(
        .WORD_W(WORD_W), .MID_W(MID_W), .MFG_ID(MFG_ID),
        .SEED_INIT(SEED_INIT), .ADV_STEPS(ADV_STEPS)
    ) u_gen (
        .clk(clk), .rst_n(rst_n),
        .load(seed_commit), .load_seed(stg_q), .adv_go(adv_go),
        .code_q(code_q), .lfsr_q(lfsr_q), .busy(adv_busy)
    );

endmodule

// File: rtl/seccode_xfer_chk.sv
module seccode_xfer_chk #(
    parameter int WORD_W    = 64,
    parameter int ADV_STEPS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              tx_req,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              rx_ack,
    input logic [WORD_W-1:0] seed_q,
    input logic [WORD_W-2:0] lfsr_q,
    input logic              adv_busy
);
    localparam int RUN_W = $clog2(ADV_STEPS + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (adv_busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R2: the stored seed only changes right after a STOP
    assert_seed_at_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_q != $past(seed_q)) |-> $past(stop_evt));

    // R4: an acknowledge is only given for a byte being received
    assert_ack_with_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> rx_valid);

    // R6: each byte request is answered exactly one cycle later
    assert_tx_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);
    assert_tx_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R7: the code register never reaches the all-zero lock-up value
    assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R8: an advance burst lasts exactly ADV_STEPS clocks
    assert_advance_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adv_busy) && !$past(stop_evt)) |-> (run_q == RUN_W'(ADV_STEPS)));

    // R9: the code moves only while advancing or on a seed commit
    assert_code_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_q != $past(lfsr_q)) |-> ($past(adv_busy) || $past(stop_evt)));

endmodule

bind seccode_xfer seccode_xfer_chk #(.WORD_W(WORD_W), .ADV_STEPS(ADV_STEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt),
    .tx_req(tx_req), .tx_valid(tx_valid),
    .rx_valid(rx_valid), .rx_ack(rx_ack),
    .seed_q(seed_q), .lfsr_q(lfsr_q), .adv_busy(adv_busy)
);

// File: tb/sim_seccode_xfer.sv
`timescale 1ns/1ps
module sim_seccode_xfer;
    localparam logic [15:0] MID   = 16'h5A3C;
    localparam logic [63:0] SINIT = 64'h0123_4567_89AB_CDEF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 0, rstart_evt = 0, stop_evt = 0, addr_evt = 0, addr_rd = 0;
    logic       rx_valid = 0, tx_req = 0, tx_ack_valid = 0, tx_ack = 0;
    logic [7:0] rx_data = 0;
    logic       rx_ack, tx_valid;
    logic [7:0] tx_data;

    int         n_cmp = 0, n_bad = 0;
    logic [63:0] m_seed;
    logic [62:0] m_lfsr;

    always #5 clk = ~clk;

    seccode_xfer #(.MFG_ID(MID), .SEED_INIT(SINIT)) u0 (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .rstart_evt(rstart_evt),
        .stop_evt(stop_evt), .addr_evt(addr_evt), .addr_rd(addr_rd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ack_valid(tx_ack_valid), .tx_ack(tx_ack)
    );

    function automatic logic [62:0] m_init(input logic [63:0] s);
        logic [63:0] x;
        x = s ^ {4{MID}};
        return (x[62:0] == 63'd0) ? 63'd1 : x[62:0];
    endfunction

    function automatic logic [62:0] m_adv(input logic [62:0] l);
        logic [62:0] v;
        v = l;
        for (int k = 0; k < 64; k++) v = {v[61:0], v[62] ^ v[61]};
        return v;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic p_start();  @(negedge clk); start_evt = 1;  @(negedge clk); start_evt = 0;  endtask
    task automatic p_rstart(); @(negedge clk); rstart_evt = 1; @(negedge clk); rstart_evt = 0; endtask
    task automatic p_stop();   @(negedge clk); stop_evt = 1;   @(negedge clk); stop_evt = 0;   endtask
    task automatic p_addr(input logic rd);
        @(negedge clk); addr_evt = 1; addr_rd = rd; @(negedge clk); addr_evt = 0;
    endtask
    task automatic send_byte(input logic [7:0] b, output logic a);
        @(negedge clk); rx_valid = 1; rx_data = b;
        #2 a = rx_ack;
        @(negedge clk); rx_valid = 0;
    endtask
    task automatic get_byte(output logic [7:0] d, input string tag);
        @(negedge clk); tx_req = 1;
        @(negedge clk); tx_req = 0;
        check({63'd0, tx_valid}, 64'd1, {tag, " tx_valid"});
        d = tx_data;
    endtask
    task automatic m_ack(input logic a);
        @(negedge clk); tx_ack_valid = 1; tx_ack = a;
        @(negedge clk); tx_ack_valid = 0;
    endtask

    // Seed write: n data bytes with count byte cb; ends with STOP or START.
    task automatic wr_seed(input logic [63:0] s, input int n, input logic [7:0] cb,
                           input bit end_start, input string tag);
        logic a;
        p_start(); p_addr(1'b0);
        send_byte(8'hC0, a); check({63'd0, a}, 64'd1, {tag, " R2 cmd ack"});
        send_byte(cb, a);    check({63'd0, a}, {63'd0, cb == 8'h08}, {tag, " R4 count ack"});
        for (int i = 0; i < n; i++) begin
            send_byte(s[63 - 8*(i % 8) -: 8], a);
            check({63'd0, a}, {63'd0, (cb == 8'h08) && (i < 8)}, {tag, " R2/R4 data ack"});
        end
        if (end_start) begin p_start(); p_stop(); end
        else p_stop();
        if (!end_start && cb == 8'h08 && n >= 8) begin
            m_seed = s;
            m_lfsr = m_init(s);
        end
        repeat (4) @(negedge clk);
    endtask

    // Read: take data bytes, NACK the last one taken (or ACK it and pull one extra).
    task automatic rd_check(input logic [7:0] cmd, input int take, input bit extra,
                            input string tag);
        logic a;
        logic [7:0] d;
        logic [63:0] exp;
        exp = (cmd == 8'hC3) ? {1'b1, m_lfsr} : m_seed;
        p_start(); p_addr(1'b0);
        send_byte(cmd, a); check({63'd0, a}, 64'd1, {tag, " R6 cmd ack"});
        p_rstart(); p_addr(1'b1);
        get_byte(d, tag); check({56'd0, d}, 64'h08, {tag, " R6 count byte"});
        m_ack(take != 0);
        for (int i = 0; i < take; i++) begin
            get_byte(d, tag);
            check({56'd0, d}, {56'd0, exp[63 - 8*i -: 8]}, {tag, " data byte"});
            m_ack((i != take - 1) || extra);
        end
        if (extra) begin
            get_byte(d, tag); check({56'd0, d}, 64'hFF, {tag, " R6 past end"});
            m_ack(1'b0);
        end
        p_stop();
        if (cmd == 8'hC3 && take == 8) m_lfsr = m_adv(m_lfsr);
        repeat (80) @(negedge clk);
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        logic [63:0] seeds [5];
        m_seed = SINIT;
        m_lfsr = m_init(SINIT);
        repeat (3) @(negedge clk);
        check({62'd0, tx_valid, rx_ack}, 64'd0, "R1 reset outputs");
        rst_n = 1;
        repeat (2) @(negedge clk);

        rd_check(8'hC1, 8, 0, "R1 seed after reset");
        for (int k = 0; k < 6; k++) rd_check(8'hC3, 8, 0, "R7/R8 code roll");

        seeds[0] = 64'hFEDC_BA98_7654_3210;
        seeds[1] = {4{MID}};
        seeds[2] = {1'b1, 63'd0} ^ {4{MID}};
        seeds[3] = 64'h0;
        seeds[4] = 64'hA5A5_0F0F_3C3C_9696;
        foreach (seeds[j]) begin
            wr_seed(seeds[j], 8, 8'h08, 0, "R2 write");
            rd_check(8'hC1, 8, 0, "R2 seed readback");
            rd_check(8'hC3, 8, 0, "R7 code after load");
            rd_check(8'hC3, 8, 0, "R8 code after advance");
        end

        for (int n = 0; n < 8; n++) begin
            wr_seed(64'h1111_2222_3333_4444 + 64'(n), n, 8'h08, 0, "R3 short+stop");
            wr_seed(64'h9999_8888_7777_6666 + 64'(n), n, 8'h08, 1, "R3 short+start");
            rd_check(8'hC1, 8, 0, "R3 seed kept");
        end

        wr_seed(64'h5555_6666_7777_8888, 8, 8'h07, 0, "R4 count 07");
        wr_seed(64'h5555_6666_7777_8888, 8, 8'h09, 0, "R4 count 09");
        wr_seed(64'h5555_6666_7777_8888, 3, 8'h00, 0, "R4 count 00");
        rd_check(8'hC1, 8, 0, "R4 seed kept");
        wr_seed(64'h0F1E_2D3C_4B5A_6978, 9, 8'h08, 0, "R4 ninth byte");
        rd_check(8'hC1, 8, 0, "R4 first eight kept");

        for (int c = 0; c < 256; c++) begin
            p_start(); p_addr(1'b0);
            send_byte(8'(c), a);
            check({63'd0, a}, {63'd0, (c == 'hC0) || (c == 'hC1) || (c == 'hC3)}, "R5 command ack");
            if (c == 'h5A || c == 'hC2 || c == 'hFF) begin
                p_rstart(); p_addr(1'b1);
                get_byte(d, "R5"); check({56'd0, d}, 64'hFF, "R5 fill after bad command");
                m_ack(1'b0);
            end
            p_stop();
        end
        rd_check(8'hC1, 8, 0, "R5 seed unchanged");

        p_start(); p_addr(1'b1);
        get_byte(d, "R6"); check({56'd0, d}, 64'hFF, "R6 read without command");
        m_ack(1'b0); p_stop();

        rd_check(8'hC3, 8, 1, "R6 extra byte");
        for (int t = 0; t < 8; t++) rd_check(8'hC3, t, 0, "R9 early NACK");
        rd_check(8'hC1, 8, 0, "R9 seed read");
        rd_check(8'hC3, 8, 0, "R9 code unchanged");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule